// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

This block is a 16-bit timer/counter controlled through a small word-addressed register interface. A programmable prescaler divides the clock, and each time it wraps the count advances by one. Three compare channels watch the count. On a hit, each channel can raise its own interrupt flag, send the count back to zero, or halt the timer by clearing its enable bit. The choice is made per channel.

A single capture channel takes in an asynchronous pin and passes it through a synchronizer. On a selected rising and/or falling transition it copies the live count into a read-only capture register. It can also raise an interrupt flag when it does so. Software clears flags by writing ones to the flag register. One interrupt output reports whether any flag is set.

The register port is a plain single-cycle control interface with no stall. A write takes effect at the clock edge where `reg_wr` is high. A read returns `reg_rdata` combinationally for the present `reg_addr`. Since no data stream enters or leaves the block, there is no valid/ready handshake and no back-pressure.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Register byte offsets are: flags 0x00, control 0x04, count 0x08, prescale limit 0x0C, prescale counter 0x10, compare actions 0x14, compare values 0x18/0x1C/0x20 for channels 0/1/2, capture control 0x28, capture value 0x2C. Writable registers read back what was written. A write to 0x2C has no effect.
- R3: Control bit 1 (hold) forces the count and the prescale counter to 0 for as long as it is set. It wins over register writes to them.
- R4: While control bit 0 (enable) is set and hold is clear, the prescale counter rises by one each clock. When it is at or above the prescale limit, it returns to 0 and the count advances, so the count advances once every limit+1 clocks. A limit of 0 advances it every clock.
- R5: Compare-action bits 3i, 3i+1 and 3i+2 give channel i its interrupt, reset and stop actions. A hit is a count advance taken while the count equals channel i's compare value. With the interrupt bit set, a hit sets flag bit i.
- R6: On a hit of a channel with its reset bit set, the count becomes 0 in place of value+1.
- R7: On a hit of a channel with its stop bit set (and reset clear), the enable bit clears and the count stays at the compare value.
- R8: Capture control bit 0 selects rising edges of `cap_pin` and bit 1 selects falling edges. On a selected edge the capture register loads the count 3 clocks after the pin change (two synchronizer stages plus the load). An unselected edge leaves it unchanged.
- R9: With capture control bit 2 set, a capture also sets flag bit 4. With bit 2 clear, it does not.
- R10: Writing a 1 to a flag bit clears it, and writing 0 leaves it unchanged. A flag set in the same cycle as its clear stays set.
- R11: `irq` is high exactly when any flag bit is set.
- R12: With enable clear the count holds its value. Writes to the count and prescale counter load the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| irq | output | 1 | OR of all interrupt flags |

## Verification
A register write lands at the edge that samples the strobe. With a limit of 0 the count moves one step per edge after enable is seen, and with limit L it moves every L+1 edges. A compare flag, reset or stop appears at the edge after the count reaches the compare value. A capture appears on the third edge after the pin moves. The bench drives and samples on falling edges, advances a counted number of edges from the write that started each scenario, and reads the result there. For capture it also reads one edge early to confirm the register has not yet changed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 32;
  localparam int NUM_MATCH = 3;
  localparam int ACT_W     = 3;
  localparam int MCR_W     = ACT_W * NUM_MATCH;
  localparam int FLAG_W    = 5;
  localparam int CAP_FLAG  = 4;
  localparam int CCTL_W    = 3;

  localparam logic [ADDR_W-1:0] OFS_FLAG  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_LIMIT = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_PCNT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ACT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_CMP0  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CCTL  = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_CAPT  = 6'h2C;

  typedef struct packed {
    logic stop;
    logic rst;
    logic intr;
  } act_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pcnt,
  output logic         tick
);
  assign tick = run && (pcnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (clr)    pcnt <= '0;
    else if (ld)     pcnt <= ld_val;
    else if (run)    pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  // R4: step by one below the limit, wrap to zero at it
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !ld && !tick) |=> (pcnt == $past(pcnt) + 1'b1));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !ld && tick) |=> (pcnt == '0));
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit import tmr_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_val,
  input  logic         tick,
  input  act_t         act,
  output logic         hit_int,
  output logic         hit_rst,
  output logic         hit_stop
);
  logic hit;
  assign hit      = tick && (cnt == cmp_val);
  assign hit_int  = hit && act.intr;
  assign hit_rst  = hit && act.rst;
  assign hit_stop = hit && act.stop;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic         sel_rise,
  input  logic         sel_fall,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap_val,
  output logic         cap_evt
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= pin;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_s = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign cap_evt = (sel_rise && pin_s && !prev_q) || (sel_fall && !pin_s && prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_val <= '0;
    else if (cap_evt) cap_val <= cnt;
  end

  // R8: a selected edge snapshots the count seen in that cycle
  a_r8_snap: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val == $past(cnt)));
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val));
endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture import tmr_pkg::*; #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cap_pin,
  output logic              irq
);
  logic              ctl_en, ctl_hold;
  logic [CNT_W-1:0]  cnt, limit, pcnt, cap_val;
  logic [MCR_W-1:0]  act_q;
  logic [CCTL_W-1:0] cctl;
  logic [FLAG_W-1:0] flags, set_mask, clr_mask;
  logic [CNT_W-1:0]  cmp_q [NUM_MATCH];
  logic [NUM_MATCH-1:0] hit_int, hit_rst, hit_stop;
  logic tick, run, cap_evt;
  logic wr_flag, wr_ctrl, wr_cnt, wr_limit, wr_pcnt, wr_act, wr_cctl;

  assign wr_flag  = reg_wr && (reg_addr == OFS_FLAG);
  assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_cnt   = reg_wr && (reg_addr == OFS_CNT);
  assign wr_limit = reg_wr && (reg_addr == OFS_LIMIT);
  assign wr_pcnt  = reg_wr && (reg_addr == OFS_PCNT);
  assign wr_act   = reg_wr && (reg_addr == OFS_ACT);
  assign wr_cctl  = reg_wr && (reg_addr == OFS_CCTL);

  assign run = ctl_en && !ctl_hold;

  tmr_prescaler #(.W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(ctl_hold), .ld(wr_pcnt),
    .ld_val(reg_wdata[CNT_W-1:0]), .limit(limit), .pcnt(pcnt), .tick(tick));

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] CMP_OFS = ADDR_W'(OFS_CMP0 + 4 * i);
    act_t act_i;
    assign act_i = act_t'(act_q[ACT_W*i +: ACT_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cmp_q[i] <= '0;
      else if (reg_wr && reg_addr == CMP_OFS) cmp_q[i] <= reg_wdata[CNT_W-1:0];
    end

    tmr_cmp_unit #(.W(CNT_W)) u_cmp (
      .cnt(cnt), .cmp_val(cmp_q[i]), .tick(tick), .act(act_i),
      .hit_int(hit_int[i]), .hit_rst(hit_rst[i]), .hit_stop(hit_stop[i]));

    // R5: an enabled interrupt action raises its flag at the next edge
    a_r5_flag: assert property (@(posedge clk) disable iff (!rst_n)
      hit_int[i] |=> flags[i]);
  end

  tmr_capture #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .sel_rise(cctl[0]), .sel_fall(cctl[1]),
    .cnt(cnt), .cap_val(cap_val), .cap_evt(cap_evt));

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit <= '0;
      act_q <= '0;
      cctl  <= '0;
    end else begin
      if (wr_limit) limit <= reg_wdata[CNT_W-1:0];
      if (wr_act)   act_q <= reg_wdata[MCR_W-1:0];
      if (wr_cctl)  cctl  <= reg_wdata[CCTL_W-1:0];
    end
  end

  // control: write wins over stop-on-match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_hold <= 1'b0;
    end else if (wr_ctrl) begin
      ctl_en   <= reg_wdata[0];
      ctl_hold <= reg_wdata[1];
    end else if (|hit_stop) begin
      ctl_en   <= 1'b0;
    end
  end

  // count: hold > write > advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (ctl_hold)     cnt <= '0;
    else if (wr_cnt)       cnt <= reg_wdata[CNT_W-1:0];
    else if (tick) begin
      if (|hit_rst)        cnt <= '0;
      else if (|hit_stop)  cnt <= cnt;
      else                 cnt <= cnt + 1'b1;
    end
  end

  // flags: set wins over write-one-to-clear
  always_comb begin
    set_mask = '0;
    set_mask[NUM_MATCH-1:0] = hit_int;
    set_mask[CAP_FLAG] = cap_evt && cctl[2];
    clr_mask = wr_flag ? reg_wdata[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_mask;
  end

  assign irq = |flags;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_FLAG:  reg_rdata = DATA_W'(flags);
      OFS_CTRL:  reg_rdata = DATA_W'({ctl_hold, ctl_en});
      OFS_CNT:   reg_rdata = DATA_W'(cnt);
      OFS_LIMIT: reg_rdata = DATA_W'(limit);
      OFS_PCNT:  reg_rdata = DATA_W'(pcnt);
      OFS_ACT:   reg_rdata = DATA_W'(act_q);
      OFS_CCTL:  reg_rdata = DATA_W'(cctl);
      OFS_CAPT:  reg_rdata = DATA_W'(cap_val);
      default: begin
        for (int i = 0; i < NUM_MATCH; i++)
          if (reg_addr == ADDR_W'(OFS_CMP0 + 4 * i)) reg_rdata = DATA_W'(cmp_q[i]);
      end
    endcase
  end

  // R3: hold forces both counters to zero
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hold |=> (cnt == '0 && pcnt == '0));
  // R6: reset-on-match returns the count to zero
  a_r6_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_rst) && !wr_cnt) |=> (cnt == '0));
  // R7: stop-on-match drops the enable
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_stop) && !wr_ctrl) |=> !ctl_en);
  // R12: a disabled count does not move unless written
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !ctl_hold && !wr_cnt) |=> $stable(cnt));
  // R10: a flag only goes away through a clear write
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: tb/sim_tmr_match_capture.sv
module sim_tmr_match_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cap_pin = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tmr_match_capture u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_pin(cap_pin), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h08, d); check("R1 count", d, 0);
    rd(6'h04, d); check("R1 control", d, 0);
    rd(6'h00, d); check("R1 flags", d, 0);
    rd(6'h2C, d); check("R1 capture", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(6'h18, 32'hBEEF); wr(6'h1C, 32'h1234); wr(6'h20, 32'h0F0F);
    wr(6'h0C, 32'h0007); wr(6'h14, 32'h1FF);
    rd(6'h18, d); check("R2 cmp0", d, 32'hBEEF);
    rd(6'h1C, d); check("R2 cmp1", d, 32'h1234);
    rd(6'h20, d); check("R2 cmp2", d, 32'h0F0F);
    rd(6'h0C, d); check("R2 limit", d, 7);
    rd(6'h14, d); check("R2 actions", d, 32'h1FF);
    wr(6'h2C, 32'h5555);
    rd(6'h2C, d); check("R2 capture read-only", d, 0);
    wr(6'h14, 0);
    wr(6'h08, 32'h00AB); wr(6'h10, 32'h0003);
    rd(6'h08, d); check("R12 count load", d, 32'hAB);
    rd(6'h10, d); check("R12 prescale counter load", d, 3);
    edges(5);
    rd(6'h08, d); check("R12 disabled count holds", d, 32'hAB);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    wr(6'h08, 5);
    wr(6'h04, 3);
    edges(2);
    rd(6'h08, d); check("R3 hold clears count", d, 0);
    rd(6'h10, d); check("R3 hold clears prescale counter", d, 0);
    wr(6'h08, 9);
    rd(6'h08, d); check("R3 hold wins over write", d, 0);
    wr(6'h04, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    wr(6'h0C, 2); wr(6'h08, 0); wr(6'h10, 0);
    wr(6'h04, 1);
    edges(8);
    rd(6'h08, d); check("R4 count after 8 clocks limit 2", d, 2);
    rd(6'h10, d); check("R4 prescale counter after 8 clocks", d, 2);
    edges(1);
    rd(6'h08, d); check("R4 count after 9 clocks limit 2", d, 3);
    rd(6'h10, d); check("R4 prescale counter wrapped", d, 0);
    wr(6'h04, 0);
  endtask

  task automatic t_match_reset();
    logic [31:0] d;
    wr(6'h0C, 0); wr(6'h18, 4); wr(6'h14, 3);
    wr(6'h08, 0); wr(6'h10, 0); wr(6'h00, 32'hFF);
    wr(6'h04, 1);
    edges(4);
    rd(6'h08, d); check("R4 limit 0 counts every clock", d, 4);
    rd(6'h00, d); check("R5 no flag before hit", d, 0);
    edges(1);
    rd(6'h08, d); check("R6 count reset on match", d, 0);
    rd(6'h00, d); check("R5 flag0 on match", d, 1);
    check("R11 irq with flag", {31'b0, irq}, 1);
    wr(6'h04, 0);
    wr(6'h00, 32'hFF);
    rd(6'h00, d); check("R10 clear all flags", d, 0);
    check("R11 irq after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_match_stop();
    logic [31:0] d;
    wr(6'h14, 32'h28); wr(6'h1C, 3); wr(6'h08, 0); wr(6'h10, 0);
    wr(6'h04, 1);
    edges(6);
    rd(6'h04, d); check("R7 enable cleared by stop", d, 0);
    rd(6'h08, d); check("R7 count held at compare", d, 3);
    rd(6'h00, d); check("R5 flag1 on match", d, 2);
    wr(6'h00, 32'hFF);
  endtask

  task automatic t_match_noint();
    logic [31:0] d;
    wr(6'h14, 32'h80); wr(6'h20, 2); wr(6'h08, 0); wr(6'h10, 0);
    wr(6'h04, 1);
    edges(3);
    rd(6'h08, d); check("R6 channel2 reset wraps", d, 0);
    rd(6'h00, d); check("R5 no flag without interrupt bit", d, 0);
    edges(2);
    rd(6'h08, d); check("R6 counting resumes after reset", d, 2);
    wr(6'h04, 0); wr(6'h14, 0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    wr(6'h00, 32'hFF);
    wr(6'h08, 32'h1234); wr(6'h28, 5);
    @(negedge clk); cap_pin = 1'b1;
    edges(2);
    rd(6'h2C, d); check("R8 capture not yet after 2 clocks", d, 0);
    edges(1);
    rd(6'h2C, d); check("R8 rising capture after 3 clocks", d, 32'h1234);
    rd(6'h00, d); check("R9 capture flag", d, 32'h10);
    check("R11 irq from capture", {31'b0, irq}, 1);
    wr(6'h00, 32'h01);
    rd(6'h00, d); check("R10 writing other bit keeps flag", d, 32'h10);
    wr(6'h00, 0);
    rd(6'h00, d); check("R10 writing zero keeps flag", d, 32'h10);
    wr(6'h08, 32'h55);
    cap_pin = 1'b0;
    edges(4);
    rd(6'h2C, d); check("R8 unselected falling edge ignored", d, 32'h1234);
    wr(6'h00, 32'h10);
    wr(6'h28, 2); wr(6'h08, 32'h77);
    cap_pin = 1'b1;
    edges(4);
    rd(6'h2C, d); check("R8 unselected rising edge ignored", d, 32'h1234);
    cap_pin = 1'b0;
    edges(4);
    rd(6'h2C, d); check("R8 falling capture", d, 32'h77);
    rd(6'h00, d); check("R9 no flag with interrupt bit clear", d, 0);
  endtask

  initial begin
    edges(2);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_regmap();
    t_hold();
    t_prescale();
    t_match_reset();
    t_match_stop();
    t_match_noint();
    t_capture();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule